// File: doc/BRIEF.md
# Per-Block Write-Protection Lock Controller

This block keeps the protection state of a small array of memory blocks, six by default. It decides in the same cycle whether an erase or program request aimed at a block may go ahead. Each block has two stored bits: a lock bit and a lock-down bit. A shared write-protect input combines with the stored bits to form the full three-bit state of each block, and that state determines how lock commands act.

Lock commands come already decoded. Each one is a single-cycle strobe with a two-bit operation code and a block index. The write-protect input gates the lock-down feature. While it is low, a locked-down block refuses Unlock. While it is high, software may unlock and relock such a block freely. When the input falls, every locked-down block is forced back to locked. A combinational status port returns the two bits of any chosen block, and both bit vectors are also exported in full.

Top module: `blk_lock_ctrl`

## Requirements
- R1: While reset is asserted, and afterwards until a command arrives, every block has lock bit 1 and lock-down bit 0.
- R2: A request (`req_vld_i`) gets `req_allow_o`=1 in the same cycle only when its index is below NUM_BLKS and that block's lock bit is 0. Otherwise it gets `req_deny_o`=1. The write-protect input and the lock-down bit have no effect on this decision. With no request, both flags are 0.
- R3: Operation code 2'b01 (Lock) sets the lock bit of the indexed block on the next clock edge.
- R4: Operation code 2'b10 (Unlock) clears the lock bit of the indexed block on the next edge. The exception is a block whose lock-down bit is set while the write-protect input is low; such a block is left unchanged.
- R5: Operation code 2'b11 (Lock-Down) sets both the lock bit and the lock-down bit of the indexed block on the next edge. Operation code 2'b00 does nothing.
- R6: When the write-protect input was high at one edge and is low at the next edge, every block whose lock-down bit is set has its lock bit set at that next edge. A locked-down block therefore stays locked for as long as the input remains low.
- R7: Once a lock-down bit is set, only reset clears it. No operation code clears it.
- R8: A command changes only the block it names. A command whose index is NUM_BLKS or higher changes no block.
- R9: The status port returns {lock-down bit, lock bit} of block `rd_idx_i` in the same cycle. An index of NUM_BLKS or higher returns 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wp_i | input | 1 | Write-protect input, synchronous to clk |
| cmd_vld_i | input | 1 | Lock command strobe |
| cmd_op_i | input | 2 | Operation: 01 Lock, 10 Unlock, 11 Lock-Down, 00 none |
| cmd_idx_i | input | IDX_W | Block addressed by the command |
| req_vld_i | input | 1 | Erase/program request valid |
| req_idx_i | input | IDX_W | Block addressed by the request |
| req_allow_o | output | 1 | Request may proceed |
| req_deny_o | output | 1 | Request refused |
| rd_idx_i | input | IDX_W | Block selected for status read |
| rd_bits_o | output | 2 | {lock-down, lock} of the selected block |
| lock_bits_o | output | NUM_BLKS | Lock bit of every block |
| ldn_bits_o | output | NUM_BLKS | Lock-down bit of every block |

## Verification
Directed sequences walk one block through every state. They cover unlocked to locked and back, lock-down with the write-protect input low and then high, and the write-protect falling edge. These sequences separate the rules that depend on the write-protect level from those that do not. Random commands, with indices that include the two unused codes and with the write-protect input toggling rarely, reach all seven states on all blocks. Against a bench model, they show whether a command leaks into a neighbouring block and whether an out-of-range index is truly ignored. Requests and status reads are issued in every cycle. This shows that the permission follows only the lock bit in every state.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'b00,
    OP_LOCK   = 2'b01,
    OP_UNLOCK = 2'b10,
    OP_LDOWN  = 2'b11
  } lock_op_e;
endpackage

// File: rtl/blk_rst_sync.sv
module blk_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/blk_lock_cell.sv
module blk_lock_cell
  import blk_lock_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wp,
  input  logic     wp_fall,
  input  logic     hit,
  input  lock_op_e op,
  output logic     lock,
  output logic     ldn
);
  logic lock_q, ldn_q, lock_d, ldn_d, en;
  logic held;

  // Locked-down with protect low: lock bit frozen at 1
  assign held = ldn_q && !wp;

  always_comb begin
    lock_d = lock_q;
    ldn_d  = ldn_q;
    if (hit) begin
      unique case (op)
        OP_LOCK:   if (!held) lock_d = 1'b1;
        OP_UNLOCK: if (!held) lock_d = 1'b0;
        OP_LDOWN:  begin lock_d = 1'b1; ldn_d = 1'b1; end
        default:   ;
      endcase
    end
    if (wp_fall && ldn_q) lock_d = 1'b1;
  end

  assign en = hit || wp_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q <= 1'b1;
      ldn_q  <= 1'b0;
    end else if (en) begin
      lock_q <= lock_d;
      ldn_q  <= ldn_d;
    end
  end

  assign lock = lock_q;
  assign ldn  = ldn_q;
endmodule

// File: rtl/blk_lock_ctrl.sv
module blk_lock_ctrl
  import blk_lock_pkg::*;
#(
  parameter int NUM_BLKS = 6,
  parameter int IDX_W    = $clog2(NUM_BLKS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wp_i,
  input  logic                cmd_vld_i,
  input  logic [1:0]          cmd_op_i,
  input  logic [IDX_W-1:0]    cmd_idx_i,
  input  logic                req_vld_i,
  input  logic [IDX_W-1:0]    req_idx_i,
  output logic                req_allow_o,
  output logic                req_deny_o,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [1:0]          rd_bits_o,
  output logic [NUM_BLKS-1:0] lock_bits_o,
  output logic [NUM_BLKS-1:0] ldn_bits_o
);
  logic     rst_int_n;
  logic     wp_q;
  logic     wp_fall;
  lock_op_e op;

  blk_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) wp_q <= 1'b0;
    else            wp_q <= wp_i;
  end

  assign wp_fall = wp_q && !wp_i;
  assign op      = lock_op_e'(cmd_op_i);

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_blk
    blk_lock_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .wp      (wp_i),
      .wp_fall (wp_fall),
      .hit     (cmd_vld_i && (cmd_idx_i == IDX_W'(b))),
      .op      (op),
      .lock    (lock_bits_o[b]),
      .ldn     (ldn_bits_o[b])
    );
  end

  logic req_open;
  always_comb begin
    req_open  = 1'b0;
    rd_bits_o = 2'b00;
    for (int b = 0; b < NUM_BLKS; b++) begin
      if (req_idx_i == IDX_W'(b)) req_open = !lock_bits_o[b];
      if (rd_idx_i == IDX_W'(b))  rd_bits_o = {ldn_bits_o[b], lock_bits_o[b]};
    end
  end

  assign req_allow_o = req_vld_i && req_open;
  assign req_deny_o  = req_vld_i && !req_open;
endmodule

// File: rtl/blk_lock_ctrl_chk.sv
module blk_lock_ctrl_chk #(
  parameter int NUM_BLKS = 6,
  parameter int IDX_W    = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wp_i,
  input logic                cmd_vld_i,
  input logic [1:0]          cmd_op_i,
  input logic [IDX_W-1:0]    cmd_idx_i,
  input logic                req_vld_i,
  input logic [IDX_W-1:0]    req_idx_i,
  input logic                req_allow_o,
  input logic                req_deny_o,
  input logic [NUM_BLKS-1:0] lock_bits_o,
  input logic [NUM_BLKS-1:0] ldn_bits_o
);
  AST_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld_i |-> (req_allow_o != req_deny_o)); // R2
  AST_FLAG_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld_i |-> (!req_allow_o && !req_deny_o)); // R2

  for (genvar b = 0; b < NUM_BLKS; b++) begin : g_chk
    AST_LOCKED_DENY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_vld_i && req_idx_i == IDX_W'(b) && lock_bits_o[b]) |-> req_deny_o); // R2
    AST_LOCK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_i && cmd_op_i == 2'b01 && cmd_idx_i == IDX_W'(b)) |=> lock_bits_o[b]); // R3
    AST_UNLOCK_WP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_i && cmd_op_i == 2'b10 && cmd_idx_i == IDX_W'(b) && wp_i) |=> !lock_bits_o[b]); // R4
    AST_LDOWN_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_vld_i && cmd_op_i == 2'b11 && cmd_idx_i == IDX_W'(b)) |=> (lock_bits_o[b] && ldn_bits_o[b])); // R5
    AST_LDN_LOW_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      (ldn_bits_o[b] && !wp_i) |=> lock_bits_o[b]); // R6
    AST_LDN_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ldn_bits_o[b] |=> ldn_bits_o[b]); // R7
  end

  AST_OOR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_i && int'(cmd_idx_i) >= NUM_BLKS && wp_i)
      |=> ($stable(lock_bits_o) && $stable(ldn_bits_o))); // R8
endmodule

bind blk_lock_ctrl blk_lock_ctrl_chk #(.NUM_BLKS(NUM_BLKS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wp_i        (wp_i),
  .cmd_vld_i   (cmd_vld_i),
  .cmd_op_i    (cmd_op_i),
  .cmd_idx_i   (cmd_idx_i),
  .req_vld_i   (req_vld_i),
  .req_idx_i   (req_idx_i),
  .req_allow_o (req_allow_o),
  .req_deny_o  (req_deny_o),
  .lock_bits_o (lock_bits_o),
  .ldn_bits_o  (ldn_bits_o)
);

// File: tb/blk_lock_ctrl_tb.sv
module blk_lock_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 6;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wp = 1'b0;
  logic          cmd_vld = 1'b0;
  logic [1:0]    cmd_op = 2'b00;
  logic [IW-1:0] cmd_idx = '0;
  logic          req_vld = 1'b0;
  logic [IW-1:0] req_idx = '0;
  logic [IW-1:0] rd_idx = '0;
  logic          allow, deny;
  logic [1:0]    rd_bits;
  logic [NB-1:0] lock_bits, ldn_bits;

  logic [NB-1:0] m_lk, m_ld;
  logic          m_wpq;
  int            checks = 0;
  int            errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blk_lock_ctrl #(.NUM_BLKS(NB), .IDX_W(IW)) u_dut (
    .clk(clk), .rst_n(rst_n), .wp_i(wp), .cmd_vld_i(cmd_vld), .cmd_op_i(cmd_op),
    .cmd_idx_i(cmd_idx), .req_vld_i(req_vld), .req_idx_i(req_idx),
    .req_allow_o(allow), .req_deny_o(deny), .rd_idx_i(rd_idx), .rd_bits_o(rd_bits),
    .lock_bits_o(lock_bits), .ldn_bits_o(ldn_bits)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_allow(logic v, logic [IW-1:0] i);
    return v && (int'(i) < NB) && !m_lk[i];
  endfunction

  function automatic logic [1:0] exp_rd(logic [IW-1:0] i);
    return (int'(i) < NB) ? {m_ld[i], m_lk[i]} : 2'b00;
  endfunction

  task automatic model_edge();
    if (cmd_vld && int'(cmd_idx) < NB) begin
      logic held = m_ld[cmd_idx] && !wp;
      case (cmd_op)
        2'b01: if (!held) m_lk[cmd_idx] = 1'b1;
        2'b10: if (!held) m_lk[cmd_idx] = 1'b0;
        2'b11: begin m_lk[cmd_idx] = 1'b1; m_ld[cmd_idx] = 1'b1; end
        default: ;
      endcase
    end
    if (m_wpq && !wp) m_lk = m_lk | m_ld;
    m_wpq = wp;
  endtask

  // One cycle: compare state, drive, check same-cycle outputs, clock the model
  task automatic step(string tag, logic w, logic cv, logic [1:0] op, logic [IW-1:0] ci,
                      logic rv, logic [IW-1:0] ri, logic [IW-1:0] di);
    @(negedge clk);
    chk({tag, " lock_bits"}, 32'(lock_bits), 32'(m_lk));
    chk({tag, " ldn_bits"}, 32'(ldn_bits), 32'(m_ld));
    wp = w; cmd_vld = cv; cmd_op = op; cmd_idx = ci;
    req_vld = rv; req_idx = ri; rd_idx = di;
    #1;
    chk("R2 allow", 32'(allow), 32'(exp_allow(rv, ri)));
    chk("R2 deny", 32'(deny), 32'(rv && !exp_allow(rv, ri)));
    chk("R9 rd_bits", 32'(rd_bits), 32'(exp_rd(di)));
    @(posedge clk);
    model_edge();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_lk = '1; m_ld = '0; m_wpq = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 lock in reset", 32'(lock_bits), 32'(m_lk));
    chk("R1 ldn in reset", 32'(ldn_bits), 32'(m_ld));
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);

    step("R1", 0, 0, 2'b00, 0, 1, 2, 2);            // locked: deny
    step("R4", 0, 1, 2'b10, 2, 1, 2, 2);            // unlock block 2
    step("R8", 0, 0, 2'b00, 0, 1, 2, 2);            // only block 2 opened, allowed
    step("R3", 0, 1, 2'b01, 2, 1, 2, 2);            // relock
    step("R3", 0, 1, 2'b10, 2, 1, 2, 2);
    step("R5", 0, 1, 2'b11, 2, 1, 2, 2);            // lock down from unlocked
    step("R5", 0, 1, 2'b10, 2, 1, 2, 2);            // unlock refused, protect low
    step("R4", 0, 1, 2'b00, 2, 1, 2, 2);            // op 00 no-op
    step("R4", 1, 1, 2'b10, 2, 1, 2, 2);            // protect high: unlock works
    step("R4", 1, 0, 2'b00, 0, 1, 2, 2);
    chk("R4 unlocked with wp high", 32'(lock_bits[2]), 32'd0);
    step("R6", 0, 0, 2'b00, 0, 1, 2, 2);            // protect falls
    step("R6", 0, 0, 2'b00, 0, 1, 2, 2);
    chk("R6 forced lock", 32'(lock_bits[2]), 32'd1);
    chk("R7 ldn kept", 32'(ldn_bits[2]), 32'd1);
    step("R8", 1, 1, 2'b11, 6, 1, 7, 7);            // out-of-range index
    step("R8", 1, 1, 2'b10, 7, 1, 6, 6);
    step("R9", 0, 1, 2'b10, 4, 1, 4, 2);
    step("R9", 0, 0, 2'b00, 0, 1, 4, 4);

    for (int n = 0; n < 3000; n++) begin
      logic w = wp;
      if ($urandom_range(0, 7) == 0) w = !wp;
      step("R3/R4/R5/R6/R7/R8", w, 1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           IW'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
           IW'($urandom_range(0, 7)), IW'($urandom_range(0, 7)));
    end

    @(negedge clk);
    chk("R7 final ldn", 32'(ldn_bits), 32'(m_ld));
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule